// File: doc/BRIEF.md
# DMA Channel Address Stepper

This block keeps the per-channel state that a DMA engine uses to walk through memory. It holds an 8-bit channel control value and a 24-bit memory address. After each completed data transfer it moves the address on by the width of the data item: one for a byte, two for a word. The direction is chosen by a control bit. Software or the bus master loads both registers through a single write port. A two-bit run mode tells the block whether the address walks or stays put.

The current address and the transfer-size bit leave the block each cycle, ready for the bus interface. A synchronous standby input clears the control value for as long as it is held. Arbitration, transfer counting, count reload and interrupts live in neighbouring blocks.

Top module: `dma_addr_step`

## Requirements
- R1: After reset the control read value is 0x00, the address is 0x000000 and word_size is 0.
- R2: A write with wr_sel=0 stores wr_data[7:0] into the control register on the next clock edge. ctrl_rd returns all eight bits unchanged, including the 4-bit field in bits 3..0.
- R3: While standby is 1 the control register is cleared at every clock edge, and control writes in those cycles are dropped. This shows as ctrl_rd = 0x00 and word_size = 0.
- R4: With control bit 7 = 0 (byte size) and bit 6 = 0 (count up), a xfer_done pulse in a walking mode adds 1 to the address.
- R5: With bit 7 = 1 (word size) and bit 6 = 0, a xfer_done pulse in a walking mode adds 2 to the address.
- R6: With bit 6 = 1 (count down), a xfer_done pulse in a walking mode subtracts 1 for byte size or 2 for word size.
- R7: The address is 24 bits wide and wraps modulo 2^24 in both directions.
- R8: In mode 2'b01 (idle) a xfer_done pulse leaves the address unchanged.
- R9: Modes 2'b00 (sequential), 2'b10 (repeat) and 2'b11 (treated as sequential) all step the address.
- R10: A write with wr_sel=1 loads wr_data into the address. If a xfer_done pulse falls in the same cycle, the loaded value wins and no step is applied.
- R11: word_size always equals control bit 7.
- R12: With no xfer_done and no address write, the address holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Clears the control register while high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 address |
| wr_data | input | 24 | Write data (control uses bits 7..0) |
| mode | input | 2 | Run mode: 00 sequential, 01 idle, 10 repeat, 11 sequential |
| xfer_done | input | 1 | One-cycle pulse per finished transfer |
| ctrl_rd | output | 8 | Stored control value |
| addr | output | 24 | Current memory address |
| word_size | output | 1 | 1 when transfers are words |

## Verification
Two events can land in the same clock edge: a bus load of the address and a transfer-done step. The bench drives a write with wr_sel=1 and a xfer_done pulse in one cycle, in several modes and sizes. It then requires the loaded value with no step on top. A second collision is a control write together with a step. The step must use the old size and direction, and the new control value must appear afterwards.

// File: rtl/dma_step_pkg.sv
package dma_step_pkg;
   localparam int CTRL_W   = 8;
   localparam int BIT_SIZE = 7;
   localparam int BIT_DOWN = 6;

   typedef enum logic [1:0] {
      MODE_SEQ     = 2'b00,
      MODE_IDLE    = 2'b01,
      MODE_RPT     = 2'b10,
      MODE_SEQ_ALT = 2'b11
   } run_mode_e;

   typedef enum logic {
      TGT_CTRL = 1'b0,
      TGT_ADDR = 1'b1
   } wr_target_e;
endpackage

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_step_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              load,
   input  logic [CTRL_W-1:0] load_data,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              word_size,
   output logic              count_down
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (standby)
         ctrl_q <= '0;
      else if (load)
         ctrl_q <= load_data;
   end

   assign word_size  = ctrl_q[BIT_SIZE];
   assign count_down = ctrl_q[BIT_DOWN];
endmodule

// File: rtl/dma_step_calc.sv
module dma_step_calc #(
   parameter int ADDR_W     = 24,
   parameter int WORD_BYTES = 2
) (
   input  logic              word_size,
   input  logic              count_down,
   input  logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] next_addr
);
   localparam logic [ADDR_W-1:0] BYTE_STEP = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

   logic [ADDR_W-1:0] step;

   generate
      if (WORD_BYTES == 1) begin : g_fixed
         assign step = BYTE_STEP;
      end else begin : g_sized
         assign step = word_size ? WORD_STEP : BYTE_STEP;
      end
   endgenerate

   always_comb begin
      if (count_down)
         next_addr = cur_addr - step;
      else
         next_addr = cur_addr + step;
   end
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_data,
   input  logic              advance,
   input  logic [ADDR_W-1:0] next_addr,
   output logic [ADDR_W-1:0] addr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr_q <= '0;
      else if (load)
         addr_q <= load_data;
      else if (advance)
         addr_q <= next_addr;
   end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step
   import dma_step_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int WORD_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              standby,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [1:0]        mode,
   input  logic              xfer_done,
   output logic [CTRL_W-1:0] ctrl_rd,
   output logic [ADDR_W-1:0] addr,
   output logic              word_size
);
   generate
      if (ADDR_W < CTRL_W) begin : g_bad_width
         $error("ADDR_W must be at least the control width");
      end
      if (WORD_BYTES < 1 || WORD_BYTES >= (1 << (ADDR_W - 1))) begin : g_bad_step
         $error("WORD_BYTES out of range for ADDR_W");
      end
   endgenerate

   logic              ctrl_load;
   logic              addr_load;
   logic              advance;
   logic              count_down;
   logic [ADDR_W-1:0] next_addr;
   run_mode_e         run_mode;

   assign run_mode  = run_mode_e'(mode);
   assign ctrl_load = wr_en && (wr_target_e'(wr_sel) == TGT_CTRL);
   assign addr_load = wr_en && (wr_target_e'(wr_sel) == TGT_ADDR);
   assign advance   = xfer_done && (run_mode != MODE_IDLE);

   dma_chan_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .standby    (standby),
      .load       (ctrl_load),
      .load_data  (wr_data[CTRL_W-1:0]),
      .ctrl_q     (ctrl_rd),
      .word_size  (word_size),
      .count_down (count_down)
   );

   dma_step_calc #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_calc (
      .word_size  (word_size),
      .count_down (count_down),
      .cur_addr   (addr),
      .next_addr  (next_addr)
   );

   dma_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (addr_load),
      .load_data (wr_data),
      .advance   (advance),
      .next_addr (next_addr),
      .addr_q    (addr)
   );
endmodule

// File: rtl/dma_addr_step_chk.sv
module dma_addr_step_chk #(
   parameter int ADDR_W     = 24,
   parameter int WORD_BYTES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              standby,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [ADDR_W-1:0] wr_data,
   input logic [1:0]        mode,
   input logic              xfer_done,
   input logic [7:0]        ctrl_rd,
   input logic [ADDR_W-1:0] addr,
   input logic              word_size
);
   logic [ADDR_W-1:0] sz;
   logic [ADDR_W-1:0] up_exp;
   logic [ADDR_W-1:0] dn_exp;
   logic              stepping;

   assign sz       = ctrl_rd[7] ? ADDR_W'(WORD_BYTES) : ADDR_W'(1);
   assign up_exp   = addr + sz;
   assign dn_exp   = addr - sz;
   assign stepping = xfer_done && (mode != 2'b01) && !(wr_en && wr_sel);

   assert_standby_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      standby |=> (ctrl_rd == 8'h00));

   assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_sel && !standby) |=> (ctrl_rd == $past(wr_data[7:0])));

   assert_step_up_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stepping && !ctrl_rd[6]) |=> (addr == $past(up_exp)));

   assert_step_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stepping && ctrl_rd[6]) |=> (addr == $past(dn_exp)));

   assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && mode == 2'b01 && !(wr_en && wr_sel)) |=> $stable(addr));

   assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (addr == $past(wr_data)));

   assert_quiet_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_done && !(wr_en && wr_sel)) |=> $stable(addr));
endmodule

bind dma_addr_step dma_addr_step_chk #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .standby   (standby),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .mode      (mode),
   .xfer_done (xfer_done),
   .ctrl_rd   (ctrl_rd),
   .addr      (addr),
   .word_size (word_size)
);

// File: tb/dma_addr_step_test.sv
module dma_addr_step_test;
   localparam int AW = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          standby = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_sel = 1'b0;
   logic [AW-1:0] wr_data = '0;
   logic [1:0]    mode = 2'b00;
   logic          xfer_done = 1'b0;
   logic [7:0]    ctrl_rd;
   logic [AW-1:0] addr;
   logic          word_size;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   dma_addr_step uut (
      .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .mode(mode), .xfer_done(xfer_done),
      .ctrl_rd(ctrl_rd), .addr(addr), .word_size(word_size)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // one cycle of stimulus, then inputs return to idle; results valid after
   task automatic cycle(logic we, logic sel, logic [AW-1:0] d, logic xd, logic [1:0] m, logic sb);
      @(negedge clk);
      wr_en = we; wr_sel = sel; wr_data = d; xfer_done = xd; mode = m; standby = sb;
      @(negedge clk);
      wr_en = 1'b0; xfer_done = 1'b0; standby = 1'b0;
   endtask

   task automatic set_ctrl(logic [7:0] v);
      cycle(1'b1, 1'b0, AW'(v), 1'b0, mode, 1'b0);
   endtask

   task automatic set_addr(logic [AW-1:0] v);
      cycle(1'b1, 1'b1, v, 1'b0, mode, 1'b0);
   endtask

   task automatic step(logic [1:0] m);
      cycle(1'b0, 1'b0, '0, 1'b1, m, 1'b0);
   endtask

   task automatic test_reset;
      check("R1 ctrl", 32'(ctrl_rd), 32'h00);
      check("R1 addr", 32'(addr), 32'h0);
      check("R1 word_size", 32'(word_size), 32'h0);
   endtask

   task automatic test_ctrl_rw;
      set_ctrl(8'h5A);
      check("R2 readback", 32'(ctrl_rd), 32'h5A);
      check("R11 size bit low", 32'(word_size), 32'h0);
      set_ctrl(8'hAF);
      check("R2 readback factor bits", 32'(ctrl_rd), 32'hAF);
      check("R11 size bit high", 32'(word_size), 32'h1);
   endtask

   task automatic test_standby;
      set_ctrl(8'hC3);
      cycle(1'b0, 1'b0, '0, 1'b0, 2'b00, 1'b1);
      check("R3 cleared", 32'(ctrl_rd), 32'h00);
      check("R3 size cleared", 32'(word_size), 32'h0);
      cycle(1'b1, 1'b0, AW'(8'hFF), 1'b0, 2'b00, 1'b1);
      check("R3 write dropped", 32'(ctrl_rd), 32'h00);
      set_ctrl(8'h81);
      check("R3 writes resume", 32'(ctrl_rd), 32'h81);
   endtask

   task automatic test_steps;
      set_ctrl(8'h00);
      set_addr(24'h001000);
      step(2'b00);
      check("R4 byte up", 32'(addr), 32'h001001);
      set_ctrl(8'h80);
      step(2'b00);
      check("R5 word up", 32'(addr), 32'h001003);
      set_ctrl(8'h40);
      step(2'b00);
      check("R6 byte down", 32'(addr), 32'h001002);
      set_ctrl(8'hC0);
      step(2'b00);
      check("R6 word down", 32'(addr), 32'h001000);
   endtask

   task automatic test_wrap;
      set_ctrl(8'h00);
      set_addr(24'hFFFFFF);
      step(2'b00);
      check("R7 byte up wrap", 32'(addr), 32'h000000);
      set_ctrl(8'hC0);
      set_addr(24'h000001);
      step(2'b00);
      check("R7 word down wrap", 32'(addr), 32'hFFFFFF);
      set_ctrl(8'h80);
      step(2'b10);
      check("R7 word up wrap", 32'(addr), 32'h000001);
   endtask

   task automatic test_modes;
      set_ctrl(8'h80);
      set_addr(24'h200000);
      step(2'b01);
      check("R8 idle hold", 32'(addr), 32'h200000);
      step(2'b10);
      check("R9 repeat steps", 32'(addr), 32'h200002);
      step(2'b11);
      check("R9 mode 11 steps", 32'(addr), 32'h200004);
      step(2'b00);
      check("R9 sequential steps", 32'(addr), 32'h200006);
      repeat (3) @(negedge clk);
      check("R12 quiet hold", 32'(addr), 32'h200006);
   endtask

   task automatic test_collisions;
      set_ctrl(8'h80);
      set_addr(24'h300000);
      cycle(1'b1, 1'b1, 24'h123456, 1'b1, 2'b00, 1'b0);
      check("R10 load beats step", 32'(addr), 32'h123456);
      cycle(1'b1, 1'b1, 24'h0000F0, 1'b1, 2'b10, 1'b0);
      check("R10 load beats step repeat", 32'(addr), 32'h0000F0);
      // control write with step: step uses old word/up setting
      cycle(1'b1, 1'b0, AW'(8'h40), 1'b1, 2'b00, 1'b0);
      check("R5 old ctrl used", 32'(addr), 32'h0000F2);
      check("R2 new ctrl stored", 32'(ctrl_rd), 32'h40);
      step(2'b00);
      check("R6 new ctrl applied", 32'(addr), 32'h0000F1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset;
      rst_n = 1'b1;
      @(negedge clk);
      test_ctrl_rw;
      test_standby;
      test_steps;
      test_wrap;
      test_modes;
      test_collisions;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule